// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Unit

This block is a shared arithmetic engine for integer multiplication and division. It handles signed and unsigned operands at two widths, a full 64-bit word and a 32-bit half word, and works on one operation at a time. A client offers an operation with a valid/ready handshake. The unit then stays busy until the result is ready. It reports completion with a one-cycle done pulse and delivers a pair of result words, a high half and a low half.

Multiplication always takes the same number of cycles for a given operand width. Division takes a number of cycles that follows the length of the quotient. A short quotient finishes early, down to a floor, and a quotient with every bit significant takes the longest. Division by zero does not trap. It returns a fixed pattern in the minimum divide time. The client can offer a new operation in the cycle where done is high, and the unit accepts it on the next clock edge.

Top module: `imd_unit`

## Requirements
- R1: `issue_ready` is the inverse of `busy`. An operation is accepted on a rising edge where `issue_valid` and `issue_ready` are both high. While `busy` is high, the handshake inputs are ignored and do not change the result of the operation in flight.
- R2: A multiply with `issue_wide`=0 raises `done` exactly 4 rising edges after the accepting edge.
- R3: A multiply with `issue_wide`=1 raises `done` exactly 6 rising edges after the accepting edge.
- R4: `issue_op`=0 selects multiply, and `issue_signed`=1 treats the operands as two's complement. For a 64-bit multiply, `res_hi` holds bits 127:64 of the 128-bit product and `res_lo` holds bits 63:0.
- R5: With `issue_wide`=0, only bits 31:0 of each operand are used. The 32-bit operation yields a 64-bit product or a 32-bit quotient and remainder. `res_hi` is bits 63:32 (or the remainder) and `res_lo` is bits 31:0 (or the quotient), each sign-extended from its bit 31 into a 64-bit output.
- R6: `issue_op`=1 selects divide. `res_lo` returns the quotient and `res_hi` the remainder. A signed quotient truncates toward zero, and a signed remainder takes the sign of the dividend.
- R7: A divide by a nonzero divisor raises `done` L rising edges after acceptance. Here L = min(73, max(21, 9 + s)), and s is the number of significant bits in the unsigned magnitude of the quotient (0 when the quotient is zero).
- R8: An unsigned 64-bit divide whose quotient has bit 63 set takes exactly 73 rising edges.
- R9: A divide by zero (divisor zero after the width selection of R5) takes 21 rising edges. It returns an all-ones `res_lo` and the dividend in `res_hi` (sign-extended from bit 31 in 32-bit mode).
- R10: `done` is high for exactly one cycle. `busy` is low in that cycle, and an operation offered then is accepted on the next rising edge.
- R11: During and right after reset, `busy`=0, `done`=0, `issue_ready`=1 and both result words are zero.
- R12: `res_hi` and `res_lo` change only in a cycle where `done` is high. Otherwise they hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Operation offered |
| issue_ready | output | 1 | Unit can accept an operation |
| issue_op | input | 1 | 0 multiply, 1 divide |
| issue_wide | input | 1 | 1 for 64-bit operands, 0 for 32-bit operands |
| issue_signed | input | 1 | 1 for two's complement operands |
| issue_a | input | 64 | Multiplicand or dividend |
| issue_b | input | 64 | Multiplier or divisor |
| busy | output | 1 | An operation is in flight |
| done | output | 1 | One-cycle completion pulse |
| res_hi | output | 64 | Product high half or remainder |
| res_lo | output | 64 | Product low half or quotient |

## Verification
The hardest cases to reach from the ports are the ends of the data-dependent divide window. At the upper end, the quotient must fill every bit. At the lower end, the quotient is short, zero, or the divisor is zero, and the latency must collapse to the floor rather than scale down. The vector table picks dividend/divisor pairs that land on each regime: all ones over one, a 2^48 dividend giving a 47-bit quotient, a dividend smaller than its divisor, and zero divisors at both widths, including a 32-bit zero divisor hidden under nonzero upper bits. Each vector is offered in the very cycle that the previous done pulse is high, so the back-to-back acceptance path is taken every time. A separate case keeps valid asserted with different operands while the unit is busy and shows that the first result is unchanged.

// File: rtl/imd_pkg.sv
`timescale 1ns/1ps
package imd_pkg;

   typedef enum logic {
      MD_MUL = 1'b0,
      MD_DIV = 1'b1
   } md_op_e;

   typedef enum logic [1:0] {
      DV_IDLE  = 2'd0,
      DV_ALIGN = 2'd1,
      DV_STEP  = 2'd2,
      DV_FIN   = 2'd3
   } dv_state_e;

endpackage

// File: rtl/imd_prep.sv
`timescale 1ns/1ps
// Operand conditioning: width selection, sign extraction, magnitude.
module imd_prep #(
   parameter int W  = 64,
   parameter int NW = 32
) (
   input  logic         wide,
   input  logic         sgn,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] mag_a,
   output logic [W-1:0] mag_b,
   output logic         neg_a,
   output logic         neg_b,
   output logic [W-1:0] ext_a
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] ea, eb;

   always_comb begin
      if (wide) begin
         ea = a;
         eb = b;
      end else if (sgn) begin
         ea = {{(W-NW){a[NW-1]}}, a[NW-1:0]};
         eb = {{(W-NW){b[NW-1]}}, b[NW-1:0]};
      end else begin
         ea = {{(W-NW){1'b0}}, a[NW-1:0]};
         eb = {{(W-NW){1'b0}}, b[NW-1:0]};
      end
      neg_a = sgn & ea[W-1];
      neg_b = sgn & eb[W-1];
      mag_a = neg_a ? (~ea + ONE) : ea;
      mag_b = neg_b ? (~eb + ONE) : eb;
      ext_a = ea;
   end
endmodule

// File: rtl/imd_mul_core.sv
`timescale 1ns/1ps
// Unsigned magnitude multiplier; product settles two edges after load.
module imd_mul_core #(
   parameter int W     = 64,
   parameter int SPLIT = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [W-1:0]   ma,
   input  logic [W-1:0]   mb,
   output logic [2*W-1:0] prod
);
   localparam int H = W / 2;

   logic [W-1:0] ma_q, mb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ma_q <= '0;
         mb_q <= '0;
      end else if (load) begin
         ma_q <= ma;
         mb_q <= mb;
      end
   end

   generate
      if (SPLIT == 0) begin : g_flat
         logic [2*W-1:0] p_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) p_q <= '0;
            else        p_q <= {{W{1'b0}}, ma_q} * {{W{1'b0}}, mb_q};
         end
         assign prod = p_q;
      end else begin : g_quarter
         logic [W-1:0]   pp_ll, pp_lh, pp_hl, pp_hh;
         logic [2*W-1:0] p_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pp_ll <= '0;
               pp_lh <= '0;
               pp_hl <= '0;
               pp_hh <= '0;
               p_q   <= '0;
            end else begin
               pp_ll <= {{H{1'b0}}, ma_q[H-1:0]} * {{H{1'b0}}, mb_q[H-1:0]};
               pp_lh <= {{H{1'b0}}, ma_q[H-1:0]} * {{H{1'b0}}, mb_q[W-1:H]};
               pp_hl <= {{H{1'b0}}, ma_q[W-1:H]} * {{H{1'b0}}, mb_q[H-1:0]};
               pp_hh <= {{H{1'b0}}, ma_q[W-1:H]} * {{H{1'b0}}, mb_q[W-1:H]};
               p_q   <= {{W{1'b0}}, pp_ll}
                      + ({{W{1'b0}}, pp_lh} << H)
                      + ({{W{1'b0}}, pp_hl} << H)
                      + {pp_hh, {W{1'b0}}};
            end
         end
         assign prod = p_q;
      end
   endgenerate
endmodule

// File: rtl/imd_div_core.sv
`timescale 1ns/1ps
// Restoring divider on magnitudes; skips the dividend/divisor leading-zero gap.
module imd_div_core
   import imd_pkg::*;
#(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dvd,
   input  logic [W-1:0] dvs,
   output logic         fin,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);
   localparam int LW = $clog2(W);
   localparam int CW = $clog2(W + 1);

   dv_state_e    st_q;
   logic [W-1:0] dvd_q, dvs_q, ds_q, quo_q, rem_q;
   logic [CW-1:0] left_q;
   logic [LW-1:0] sh;

   function automatic logic [LW-1:0] top_bit(input logic [W-1:0] v);
      logic [LW-1:0] p;
      p = '0;
      for (int i = 0; i < W; i++) begin
         if (v[i]) p = LW'(i);
      end
      return p;
   endfunction

   assign sh = top_bit(dvd_q) - top_bit(dvs_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= DV_IDLE;
         dvd_q  <= '0;
         dvs_q  <= '0;
         ds_q   <= '0;
         quo_q  <= '0;
         rem_q  <= '0;
         left_q <= '0;
      end else if (start) begin
         dvd_q <= dvd;
         dvs_q <= dvs;
         st_q  <= DV_ALIGN;
      end else begin
         case (st_q)
            DV_ALIGN: begin
               quo_q <= '0;
               rem_q <= dvd_q;
               if ((dvs_q == '0) || (dvd_q < dvs_q)) begin
                  st_q <= DV_FIN;
               end else begin
                  ds_q   <= dvs_q << sh;
                  left_q <= CW'(sh) + CW'(1);
                  st_q   <= DV_STEP;
               end
            end
            DV_STEP: begin
               if (rem_q >= ds_q) begin
                  rem_q <= rem_q - ds_q;
                  quo_q <= {quo_q[W-2:0], 1'b1};
               end else begin
                  quo_q <= {quo_q[W-2:0], 1'b0};
               end
               ds_q   <= ds_q >> 1;
               left_q <= left_q - CW'(1);
               if (left_q == CW'(1)) st_q <= DV_FIN;
            end
            default: ;
         endcase
      end
   end

   assign fin = (st_q == DV_FIN);
   assign quo = quo_q;
   assign rem = rem_q;
endmodule

// File: rtl/imd_unit.sv
`timescale 1ns/1ps
module imd_unit
   import imd_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter int NLEN        = 32,
   parameter int MUL_LAT_N   = 4,
   parameter int MUL_LAT_W   = 6,
   parameter int DIV_LAT_MIN = 21,
   parameter int DIV_LAT_MAX = 73,
   parameter int MUL_SPLIT   = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            issue_valid,
   output logic            issue_ready,
   input  logic            issue_op,
   input  logic            issue_wide,
   input  logic            issue_signed,
   input  logic [XLEN-1:0] issue_a,
   input  logic [XLEN-1:0] issue_b,
   output logic            busy,
   output logic            done,
   output logic [XLEN-1:0] res_hi,
   output logic [XLEN-1:0] res_lo
);
   localparam int DIV_OVH = DIV_LAT_MAX - XLEN;
   localparam int CNTW    = $clog2(DIV_LAT_MAX + 1);
   localparam int SW      = $clog2(XLEN + 1);
   localparam logic [XLEN-1:0]   ONE_W = XLEN'(1);
   localparam logic [2*XLEN-1:0] ONE_P = (2*XLEN)'(1);

   // elaboration-time parameter checks
   if (NLEN >= XLEN || (XLEN % 2) != 0) begin : g_bad_width
      $error("imd_unit: NLEN must be below an even XLEN");
   end
   if (DIV_OVH < 3 || DIV_LAT_MIN < 3 || DIV_LAT_MIN > DIV_LAT_MAX) begin : g_bad_div
      $error("imd_unit: divide latency window too tight");
   end
   if (MUL_LAT_N < 3 || MUL_LAT_W < MUL_LAT_N) begin : g_bad_mul
      $error("imd_unit: multiply latency below datapath depth");
   end

   logic            busy_q, done_q, wide_q, negp_q, negr_q, dz_q;
   md_op_e          op_q;
   logic [CNTW-1:0] cnt_q, tgt;
   logic            tgt_ok, accept, finish;
   logic [XLEN-1:0] exta_q, hi_q, lo_q;

   logic [XLEN-1:0]   mag_a, mag_b, ext_a;
   logic              neg_a, neg_b;
   logic [2*XLEN-1:0] prod;
   logic              dv_fin;
   logic [XLEN-1:0]   dv_quo, dv_rem;
   logic [SW-1:0]     q_sig;

   assign accept      = issue_valid & ~busy_q;
   assign issue_ready = ~busy_q;
   assign busy        = busy_q;
   assign done        = done_q;
   assign res_hi      = hi_q;
   assign res_lo      = lo_q;

   imd_prep #(.W(XLEN), .NW(NLEN)) prep_i (
      .wide  (issue_wide),
      .sgn   (issue_signed),
      .a     (issue_a),
      .b     (issue_b),
      .mag_a (mag_a),
      .mag_b (mag_b),
      .neg_a (neg_a),
      .neg_b (neg_b),
      .ext_a (ext_a)
   );

   imd_mul_core #(.W(XLEN), .SPLIT(MUL_SPLIT)) mul_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept & (issue_op == MD_MUL)),
      .ma    (mag_a),
      .mb    (mag_b),
      .prod  (prod)
   );

   imd_div_core #(.W(XLEN)) div_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept & (issue_op == MD_DIV)),
      .dvd   (mag_a),
      .dvs   (mag_b),
      .fin   (dv_fin),
      .quo   (dv_quo),
      .rem   (dv_rem)
   );

   function automatic logic [SW-1:0] sig_bits(input logic [XLEN-1:0] v);
      logic [SW-1:0] s;
      s = '0;
      for (int i = 0; i < XLEN; i++) begin
         if (v[i]) s = SW'(i + 1);
      end
      return s;
   endfunction

   function automatic logic [XLEN-1:0] sx_half(input logic [XLEN-1:0] v);
      return {{(XLEN-NLEN){v[NLEN-1]}}, v[NLEN-1:0]};
   endfunction

   assign q_sig = sig_bits(dv_quo);

   // completion target in cycles since acceptance
   always_comb begin
      int raw;
      raw    = DIV_OVH + int'(q_sig);
      if (raw < DIV_LAT_MIN) raw = DIV_LAT_MIN;
      if (raw > DIV_LAT_MAX) raw = DIV_LAT_MAX;
      tgt    = '0;
      tgt_ok = 1'b0;
      if (op_q == MD_MUL) begin
         tgt    = wide_q ? CNTW'(MUL_LAT_W) : CNTW'(MUL_LAT_N);
         tgt_ok = 1'b1;
      end else if (dz_q) begin
         tgt    = CNTW'(DIV_LAT_MIN);
         tgt_ok = 1'b1;
      end else if (dv_fin) begin
         tgt    = CNTW'(raw);
         tgt_ok = 1'b1;
      end
   end

   assign finish = busy_q & tgt_ok & (cnt_q == tgt);

   // signed result formation
   logic [2*XLEN-1:0] p_sgn;
   logic [XLEN-1:0]   q_sgn, r_sgn, nx_hi, nx_lo;

   always_comb begin
      p_sgn = negp_q ? (~prod + ONE_P) : prod;
      q_sgn = dz_q ? '1 : (negp_q ? (~dv_quo + ONE_W) : dv_quo);
      r_sgn = dz_q ? exta_q : (negr_q ? (~dv_rem + ONE_W) : dv_rem);
      if (op_q == MD_MUL) begin
         if (wide_q) begin
            nx_hi = p_sgn[2*XLEN-1:XLEN];
            nx_lo = p_sgn[XLEN-1:0];
         end else begin
            nx_hi = sx_half(p_sgn[XLEN-1:0] >> NLEN);
            nx_lo = sx_half(p_sgn[XLEN-1:0]);
         end
      end else begin
         nx_hi = wide_q ? r_sgn : sx_half(r_sgn);
         nx_lo = wide_q ? q_sgn : sx_half(q_sgn);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
         op_q   <= MD_MUL;
         wide_q <= 1'b0;
         negp_q <= 1'b0;
         negr_q <= 1'b0;
         dz_q   <= 1'b0;
         exta_q <= '0;
         hi_q   <= '0;
         lo_q   <= '0;
      end else begin
         done_q <= finish;
         if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= CNTW'(1);
            op_q   <= md_op_e'(issue_op);
            wide_q <= issue_wide;
            negp_q <= neg_a ^ neg_b;
            negr_q <= neg_a;
            dz_q   <= (issue_op == MD_DIV) && (mag_b == '0);
            exta_q <= ext_a;
         end else if (busy_q) begin
            cnt_q <= cnt_q + CNTW'(1);
            if (finish) begin
               busy_q <= 1'b0;
               hi_q   <= nx_hi;
               lo_q   <= nx_lo;
            end
         end
      end
   end
endmodule

// File: rtl/imd_unit_chk.sv
`timescale 1ns/1ps
module imd_unit_chk #(
   parameter int XLEN        = 64,
   parameter int MUL_LAT_N   = 4,
   parameter int MUL_LAT_W   = 6,
   parameter int DIV_LAT_MIN = 21,
   parameter int DIV_LAT_MAX = 73
) (
   input logic            clk,
   input logic            rst_n,
   input logic            issue_valid,
   input logic            issue_ready,
   input logic            issue_op,
   input logic            issue_wide,
   input logic            busy,
   input logic            done,
   input logic [XLEN-1:0] res_hi,
   input logic [XLEN-1:0] res_lo
);
   localparam int CW = $clog2(DIV_LAT_MAX + 2) + 1;

   logic [CW-1:0] c_cnt;
   logic          c_op, c_wide;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_cnt  <= '0;
         c_op   <= 1'b0;
         c_wide <= 1'b0;
      end else if (issue_valid && issue_ready) begin
         c_cnt  <= '0;
         c_op   <= issue_op;
         c_wide <= issue_wide;
      end else if (busy) begin
         c_cnt <= c_cnt + CW'(1);
      end
   end

   AST_BUSY_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !issue_ready);  // R1
   AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_ready) |=> (busy && !done));  // R1
   AST_MUL_NARROW_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !c_op && !c_wide) |-> (c_cnt == CW'(MUL_LAT_N)));  // R2
   AST_MUL_WIDE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !c_op && c_wide) |-> (c_cnt == CW'(MUL_LAT_W)));  // R3
   AST_DIV_LAT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (done && c_op) |-> ((c_cnt >= CW'(DIV_LAT_MIN)) && (c_cnt <= CW'(DIV_LAT_MAX))));  // R7
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);  // R10
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);  // R10
   AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);  // R10
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(res_hi) && $stable(res_lo)));  // R12
endmodule

bind imd_unit imd_unit_chk #(
   .XLEN        (XLEN),
   .MUL_LAT_N   (MUL_LAT_N),
   .MUL_LAT_W   (MUL_LAT_W),
   .DIV_LAT_MIN (DIV_LAT_MIN),
   .DIV_LAT_MAX (DIV_LAT_MAX)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_valid (issue_valid),
   .issue_ready (issue_ready),
   .issue_op    (issue_op),
   .issue_wide  (issue_wide),
   .busy        (busy),
   .done        (done),
   .res_hi      (res_hi),
   .res_lo      (res_lo)
);

// File: tb/imd_unit_tb_top.sv
`timescale 1ns/1ps
module imd_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid = 1'b0;
   logic        issue_ready;
   logic        issue_op = 1'b0;
   logic        issue_wide = 1'b0;
   logic        issue_signed = 1'b0;
   logic [63:0] issue_a = '0;
   logic [63:0] issue_b = '0;
   logic        busy, done;
   logic [63:0] res_hi, res_lo;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #2.5 clk = ~clk;

   imd_unit dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .issue_valid  (issue_valid),
      .issue_ready  (issue_ready),
      .issue_op     (issue_op),
      .issue_wide   (issue_wide),
      .issue_signed (issue_signed),
      .issue_a      (issue_a),
      .issue_b      (issue_b),
      .busy         (busy),
      .done         (done),
      .res_hi       (res_hi),
      .res_lo       (res_lo)
   );

   // op, wide, signed, a, b
   localparam int NV = 15;
   localparam bit V_OP [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0};
   localparam bit V_WD [NV] = '{0, 0, 1, 1, 0, 1, 1, 1, 0, 1, 1, 0, 1, 0, 0};
   localparam bit V_SG [NV] = '{0, 1, 0, 1, 1, 0, 0, 1, 1, 0, 0, 0, 1, 0, 0};
   localparam logic [63:0] V_A [NV] = '{
      64'h0000_0000_1234_5678, 64'hFFFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFF,
      64'hFFFF_FFFF_FFFF_FFFB, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
      64'd100,                 64'hFFFF_FFFF_FFFF_FF9C, 64'd7,
      64'h0001_0000_0000_0000, 64'd5,                   64'h0000_0000_FFFF_FFFF,
      64'hFFFF_FFFF_FFFF_FFD6, 64'h0000_0000_8000_0001, 64'hDEAD_BEEF_0000_0003};
   localparam logic [63:0] V_B [NV] = '{
      64'h0000_0000_9ABC_DEF0, 64'd7,                   64'hFFFF_FFFF_FFFF_FFFF,
      64'h0000_0001_0000_0000, 64'h0000_0000_8000_0000, 64'd1,
      64'd7,                   64'd7,                   64'h0000_0000_FFFF_FFFE,
      64'd3,                   64'd9,                   64'd1,
      64'd0,                   64'hFFFF_FFFF_0000_0000, 64'h1234_5678_0000_0005};

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] sx32(input logic [31:0] v);
      return {{32{v[31]}}, v};
   endfunction

   // Reference model built from the requirements
   function automatic void model(input bit op, input bit wd, input bit sg,
                                 input logic [63:0] a, input logic [63:0] b,
                                 output logic [63:0] hi, output logic [63:0] lo,
                                 output int lat);
      logic [63:0]  ea, eb, ma, mb, qm, q, r, p64;
      logic [127:0] p;
      int s;
      if (wd) begin
         ea = a; eb = b;
      end else if (sg) begin
         ea = sx32(a[31:0]); eb = sx32(b[31:0]);
      end else begin
         ea = {32'b0, a[31:0]}; eb = {32'b0, b[31:0]};
      end
      if (!op) begin
         lat = wd ? 6 : 4;
         if (wd) begin
            if (sg) p = $signed({{64{ea[63]}}, ea}) * $signed({{64{eb[63]}}, eb});
            else    p = {64'b0, ea} * {64'b0, eb};
            hi = p[127:64]; lo = p[63:0];
         end else begin
            p64 = ea * eb;
            hi = sx32(p64[63:32]); lo = sx32(p64[31:0]);
         end
      end else if (eb == 64'd0) begin
         lat = 21;
         lo  = '1;
         hi  = wd ? a : sx32(a[31:0]);
      end else begin
         ma = (sg && ea[63]) ? -ea : ea;
         mb = (sg && eb[63]) ? -eb : eb;
         qm = ma / mb;
         if (sg) begin
            q = $signed(ea) / $signed(eb);
            r = $signed(ea) % $signed(eb);
         end else begin
            q = ea / eb;
            r = ea % eb;
         end
         s = 0;
         for (int i = 0; i < 64; i++) if (qm[i]) s = i + 1;
         lat = 9 + s;
         if (lat < 21) lat = 21;
         if (lat > 73) lat = 73;
         lo = wd ? q : sx32(q[31:0]);
         hi = wd ? r : sx32(r[31:0]);
      end
   endfunction

   // Called at a negedge; drives, waits for done, checks. Returns at the done negedge.
   task automatic run_op(input int idx);
      logic [63:0] eh, el;
      int el_lat, n;
      string ltag, rtag;
      bit op, wd, sg;
      op = V_OP[idx]; wd = V_WD[idx]; sg = V_SG[idx];
      model(op, wd, sg, V_A[idx], V_B[idx], eh, el, el_lat);
      if (!op) ltag = wd ? "R3" : "R2";
      else if ((wd ? V_B[idx] : {32'b0, V_B[idx][31:0]}) == 64'd0) ltag = "R9";
      else if (el_lat == 73) ltag = "R8";
      else ltag = "R7";
      rtag = !op ? (wd ? "R4" : "R4/R5") : (ltag == "R9" ? "R9" : (wd ? "R6" : "R6/R5"));
      issue_valid = 1'b1; issue_op = op; issue_wide = wd; issue_signed = sg;
      issue_a = V_A[idx]; issue_b = V_B[idx];
      @(posedge clk);
      @(negedge clk);
      issue_valid = 1'b0;
      chk($sformatf("R1 vec%0d busy after accept", idx), {63'b0, busy & ~issue_ready}, 64'd1);
      chk($sformatf("R10 vec%0d done not held", idx), {63'b0, done}, 64'd0);
      n = 0;
      while (!done && n < 200) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      chk($sformatf("%s vec%0d latency", ltag, idx), 64'(n), 64'(el_lat));
      chk($sformatf("%s vec%0d res_hi", rtag, idx), res_hi, eh);
      chk($sformatf("%s vec%0d res_lo", rtag, idx), res_lo, el);
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<=100000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin : main
      logic [63:0] hold_hi, hold_lo;
      int n;
      // R11: reset state
      repeat (3) @(negedge clk);
      chk("R11 busy in reset", {63'b0, busy}, 64'd0);
      chk("R11 done in reset", {63'b0, done}, 64'd0);
      chk("R11 ready in reset", {63'b0, issue_ready}, 64'd1);
      chk("R11 res_hi in reset", res_hi, 64'd0);
      chk("R11 res_lo in reset", res_lo, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 ready after reset", {63'b0, issue_ready}, 64'd1);

      // Vector table: each issue lands in the previous done cycle (R10)
      for (int i = 0; i < NV; i++) run_op(i);

      // R1: operands offered while busy are ignored
      @(negedge clk);
      issue_valid = 1'b1; issue_op = 1'b0; issue_wide = 1'b1; issue_signed = 1'b0;
      issue_a = 64'd3; issue_b = 64'd5;
      @(posedge clk);
      @(negedge clk);
      issue_op = 1'b1; issue_a = 64'd100; issue_b = 64'd7;
      n = 0;
      repeat (3) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      issue_valid = 1'b0;
      while (!done && n < 200) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      chk("R1 busy issue ignored latency", 64'(n), 64'd6);
      chk("R1 busy issue ignored res_lo", res_lo, 64'd15);
      chk("R1 busy issue ignored res_hi", res_hi, 64'd0);
      hold_hi = res_hi; hold_lo = res_lo;

      // R12: results hold while idle
      repeat (5) @(negedge clk);
      chk("R1 no late accept", {63'b0, busy}, 64'd0);
      chk("R12 idle done", {63'b0, done}, 64'd0);
      chk("R12 res_hi held", res_hi, hold_hi);
      chk("R12 res_lo held", res_lo, hold_lo);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule